// File: doc/BRIEF.md
# Parallel SPI Bit-Plane Loader

This block runs a group of serial-interface memories in lockstep, each memory holding one bit-plane of a picture. Every memory sees the same serial clock and the same active-low select. Command and address bits are copied onto every serial input at once. During a load, each device instead takes its own bit of the CPU data byte. On the return side, each device's serial output feeds its own luma output bit. One CPU transfer therefore moves one bit into every fitted device. One pixel slot likewise pulls one bit out of every fitted device.

A frame-start pulse opens a read at address zero on all devices together. After the command header has gone out, each pixel strobe latches the current serial outputs onto the luma bits and gives the devices one clock pulse, so the next bit is ready for the next slot. The CPU loads the devices through two write-only registers on the same shared bus. A control register opens or closes a load session. A data register shifts one bit per device. A load session has priority over frame reads, and vertical blanking closes any read.

Top module: `bitslice_spi_loader`

## Requirements
- R1: While reset is held and right after it, spi_cs_n is 1, spi_sck is 0, every spi_mosi bit is 0 and luma_out is 0.
- R2: A frame_start seen with vblank low and no load session open first drives spi_cs_n high for one clock. It then drives spi_cs_n low and sends opcode 0x03 followed by the 16-bit address 0x0000, most significant bit first. The same bit goes on every spi_mosi bit, using 24 spi_sck pulses, and the read phase is entered 49 clocks after the edge that took frame_start.
- R3: In the read phase, a pix_stb taken while spi_sck is low copies spi_miso[k] into luma_out[k] and gives one spi_sck pulse. A pix_stb taken while spi_sck is high, or outside the read phase, is ignored: luma_out holds and no pulse is made.
- R4: SPI mode 0: spi_sck is low whenever spi_cs_n is high, each spi_sck high lasts one clock, and spi_mosi is already settled in the clock before spi_sck rises and stays unchanged while it is high.
- R5: While vblank is high and no load session is open, spi_cs_n is high from the next clock on, and frame_start is ignored.
- R6: A CPU write with cpu_addr=0 and cpu_wdata[0]=1 opens a load session. After a one-clock spi_cs_n-high gap, opcode 0x06 is sent to all devices as a transaction of its own. After a further one-clock gap, opcode 0x02 and address 0x0000 are sent to all devices, and spi_cs_n is then kept low.
- R7: In a load session, a CPU write with cpu_addr=1 drives cpu_wdata[7-k] onto spi_mosi[k] and gives one spi_sck pulse. Each such write moves one bit into every device, and successive writes fill each device byte most significant bit first. cpu_wdata bits below the fitted devices are unused.
- R8: A data write (cpu_addr=1) is ignored when no load session is in its data phase, or when it comes while the previous bit's pulse is still running (the two clocks after an accepted data write).
- R9: A CPU write with cpu_addr=0 and cpu_wdata[0]=0 during a load session ends it, and spi_cs_n is high from the next clock on.
- R10: During a load session, frame_start and vblank have no effect. When an open request and frame_start arrive in the same clock, the load session starts and the read does not.
- R11: A frame_start during a read restarts it: spi_cs_n goes high for one clock, and the header is sent again, so the next pixel is bit 7 of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-clock pulse at the start of a video frame |
| vblank | input | 1 | High during vertical blanking |
| pix_stb | input | 1 | One-clock pulse per pixel slot |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 1 | Register select: 0 control, 1 data |
| cpu_wdata | input | CPU_DW | CPU write data |
| spi_sck | output | 1 | Shared serial clock |
| spi_cs_n | output | 1 | Shared active-low select |
| spi_mosi | output | N_DEV | Serial input of each device |
| spi_miso | input | N_DEV | Serial output of each device |
| luma_out | output | N_DEV | Luma bits, one per device |

## Verification
A load-open request and a frame-start pulse can land in the same clock. The bench drives both on one edge. It then checks that the select shows the short gap after 17 clocks and that every modelled device has its write-enable latch set, which only the 0x06 command can cause. It also holds pixel strobe high across the serial clock's high phase. The bench requires exactly one clock pulse, and requires that the next strobe delivers the following bit rather than a skipped one. Behavioural device models in the bench decode the commands, so stored and streamed bits are compared with values worked out from the load table.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SHIFT,
    ST_STREAM,
    ST_LOAD
  } st_e;

  typedef enum logic [1:0] {
    TG_RD,
    TG_WREN,
    TG_WR
  } tg_e;

  localparam int          OPC_W    = 8;
  localparam logic [7:0]  OPC_READ = 8'h03;
  localparam logic [7:0]  OPC_PROG = 8'h02;
  localparam logic [7:0]  OPC_WREN = 8'h06;
endpackage

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
  import bsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       vblank,
  input  logic       pix_stb,
  input  logic       ctl_open,
  input  logic       ctl_close,
  input  logic       dat_wr,
  input  logic       hdr_last,
  output st_e        st_o,
  output tg_e        tg_o,
  output logic [1:0] ph_o,
  output logic       hdr_load,
  output logic       hdr_step,
  output logic       cap_en,
  output logic       bit_cap,
  output logic       in_load
);
  st_e        st, st_n;
  tg_e        tg, tg_n;
  logic [1:0] ph, ph_n;
  logic       run;

  // next-state: session control has priority, then blanking, then frame
  always_comb begin
    st_n     = st;
    tg_n     = tg;
    ph_n     = ph;
    hdr_load = 1'b0;
    hdr_step = 1'b0;
    cap_en   = 1'b0;
    bit_cap  = 1'b0;
    run      = 1'b0;
    in_load  = (st != ST_IDLE) && (tg != TG_RD);

    if (in_load) begin
      if (ctl_close) begin
        st_n = ST_IDLE;
        ph_n = 2'd0;
      end else begin
        run = 1'b1;
      end
    end else if (ctl_open) begin
      st_n = ST_GAP;
      tg_n = TG_WREN;
      ph_n = 2'd0;
    end else if (vblank) begin
      st_n = ST_IDLE;
      ph_n = 2'd0;
    end else if (frame_start) begin
      st_n = ST_GAP;
      tg_n = TG_RD;
      ph_n = 2'd0;
    end else begin
      run = 1'b1;
    end

    if (run) begin
      case (st)
        ST_GAP: begin
          hdr_load = 1'b1;
          st_n     = ST_SHIFT;
          ph_n     = 2'd0;
        end
        ST_SHIFT: begin
          if (ph == 2'd0) begin
            ph_n = 2'd2;
          end else begin
            ph_n     = 2'd0;
            hdr_step = 1'b1;
            if (hdr_last) begin
              case (tg)
                TG_WREN: begin
                  st_n = ST_GAP;
                  tg_n = TG_WR;
                end
                TG_WR:   st_n = ST_LOAD;
                default: st_n = ST_STREAM;
              endcase
            end
          end
        end
        ST_STREAM: begin
          if (ph == 2'd0) begin
            if (pix_stb) begin
              cap_en = 1'b1;
              ph_n   = 2'd2;
            end
          end else begin
            ph_n = 2'd0;
          end
        end
        ST_LOAD: begin
          case (ph)
            2'd0: begin
              if (dat_wr) begin
                bit_cap = 1'b1;
                ph_n    = 2'd1;
              end
            end
            2'd1:    ph_n = 2'd2;
            default: ph_n = 2'd0;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      tg <= TG_RD;
      ph <= 2'd0;
    end else begin
      st <= st_n;
      tg <= tg_n;
      ph <= ph_n;
    end
  end

  assign st_o = st;
  assign tg_o = tg;
  assign ph_o = ph;
endmodule

// File: rtl/bsl_hdr_shift.sv
module bsl_hdr_shift
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  tg_e  kind,
  input  logic step,
  output logic hdr_bit,
  output logic hdr_last
);
  localparam int HDR_W = OPC_W + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W);

  logic [HDR_W-1:0] sh, sh_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [7:0]       opc;

  always_comb begin
    case (kind)
      TG_WREN: opc = OPC_WREN;
      TG_WR:   opc = OPC_PROG;
      default: opc = OPC_READ;
    endcase
  end

  always_comb begin
    sh_n  = sh;
    cnt_n = cnt;
    if (load) begin
      sh_n  = {opc, {ADDR_W{1'b0}}};
      cnt_n = (kind == TG_WREN) ? CNT_W'(OPC_W - 1) : CNT_W'(HDR_W - 1);
    end else if (step) begin
      sh_n = {sh[HDR_W-2:0], 1'b0};
      if (cnt != '0) cnt_n = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else begin
      sh  <= sh_n;
      cnt <= cnt_n;
    end
  end

  assign hdr_bit  = sh[HDR_W-1];
  assign hdr_last = (cnt == '0);
endmodule

// File: rtl/bsl_slice.sv
module bsl_slice
  import bsl_pkg::*;
#(
  parameter int N_DEV  = 2,
  parameter int CPU_DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               st,
  input  logic              hdr_bit,
  input  logic              bit_cap,
  input  logic              cap_en,
  input  logic [CPU_DW-1:0] cpu_wdata,
  input  logic [N_DEV-1:0]  miso,
  output logic [N_DEV-1:0]  mosi,
  output logic [N_DEV-1:0]  luma
);
  logic [N_DEV-1:0] ld_q;
  logic [N_DEV-1:0] luma_q;

  for (genvar k = 0; k < N_DEV; k++) begin : g_dev
    logic ld_n, luma_n;

    always_comb begin
      ld_n   = bit_cap ? cpu_wdata[CPU_DW-1-k] : ld_q[k];
      luma_n = cap_en  ? miso[k]               : luma_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ld_q[k]   <= 1'b0;
        luma_q[k] <= 1'b0;
      end else begin
        ld_q[k]   <= ld_n;
        luma_q[k] <= luma_n;
      end
    end

    always_comb begin
      case (st)
        ST_SHIFT: mosi[k] = hdr_bit;
        ST_LOAD:  mosi[k] = ld_q[k];
        default:  mosi[k] = 1'b0;
      endcase
    end
  end

  if (N_DEV < CPU_DW) begin : g_spare
    logic unused_low_bits;
    assign unused_low_bits = ^cpu_wdata[CPU_DW-N_DEV-1:0];
  end

  assign luma = luma_q;
endmodule

// File: rtl/bitslice_spi_loader.sv
module bitslice_spi_loader
  import bsl_pkg::*;
#(
  parameter int N_DEV  = 2,
  parameter int ADDR_W = 16,
  parameter int CPU_DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              vblank,
  input  logic              pix_stb,
  input  logic              cpu_wr,
  input  logic              cpu_addr,
  input  logic [CPU_DW-1:0] cpu_wdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic [N_DEV-1:0]  spi_mosi,
  input  logic [N_DEV-1:0]  spi_miso,
  output logic [N_DEV-1:0]  luma_out
);
  st_e        st;
  tg_e        tg;
  logic [1:0] ph;
  logic       ctl_open, ctl_close, dat_wr;
  logic       hdr_load, hdr_step, hdr_last, hdr_bit;
  logic       cap_en, bit_cap, in_load;

  assign ctl_open  = cpu_wr && !cpu_addr &&  cpu_wdata[0];
  assign ctl_close = cpu_wr && !cpu_addr && !cpu_wdata[0];
  assign dat_wr    = cpu_wr &&  cpu_addr;

  bsl_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .vblank      (vblank),
    .pix_stb     (pix_stb),
    .ctl_open    (ctl_open),
    .ctl_close   (ctl_close),
    .dat_wr      (dat_wr),
    .hdr_last    (hdr_last),
    .st_o        (st),
    .tg_o        (tg),
    .ph_o        (ph),
    .hdr_load    (hdr_load),
    .hdr_step    (hdr_step),
    .cap_en      (cap_en),
    .bit_cap     (bit_cap),
    .in_load     (in_load)
  );

  bsl_hdr_shift #(.ADDR_W(ADDR_W)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hdr_load),
    .kind     (tg),
    .step     (hdr_step),
    .hdr_bit  (hdr_bit),
    .hdr_last (hdr_last)
  );

  bsl_slice #(.N_DEV(N_DEV), .CPU_DW(CPU_DW)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .hdr_bit   (hdr_bit),
    .bit_cap   (bit_cap),
    .cap_en    (cap_en),
    .cpu_wdata (cpu_wdata),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .luma      (luma_out)
  );

  // select is released only in idle and in the one-clock gap state
  assign spi_cs_n = (st == ST_IDLE) || (st == ST_GAP);
  assign spi_sck  = ph[1];
endmodule

// File: rtl/bsl_chk.sv
module bsl_chk #(
  parameter int N_DEV = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vblank,
  input logic             pix_stb,
  input logic             spi_sck,
  input logic             spi_cs_n,
  input logic [N_DEV-1:0] spi_mosi,
  input logic [N_DEV-1:0] luma_out,
  input logic             in_load,
  input logic             ctl_close
);
  // R4: serial data does not move while the clock is high
  a_r4_mosi_settled: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  // R4: clock idles low with the select released
  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R4: every clock high phase lasts exactly one cycle
  a_r4_sck_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |=> !spi_sck);

  // R3: luma moves only on a pixel strobe
  a_r3_luma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> $stable(luma_out));

  // R5: blanking outside a load session releases the select
  a_r5_vblank_release: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !in_load) |=> spi_cs_n);

  // R10: a load session persists until closed
  a_r10_session_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && !ctl_close) |=> in_load);
endmodule

bind bitslice_spi_loader bsl_chk #(.N_DEV(N_DEV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vblank    (vblank),
  .pix_stb   (pix_stb),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi),
  .luma_out  (luma_out),
  .in_load   (in_load),
  .ctl_close (ctl_close)
);

// File: tb/bitslice_spi_loader_tb.sv
`timescale 1ns/1ps
module bitslice_spi_loader_tb;
  localparam int ND = 2;
  localparam int NV = 8;
  // [15:8] byte stored in device 0, [7:0] byte stored in device 1
  localparam logic [15:0] VEC [NV] = '{16'hA53C, 16'h0FF0, 16'h8001, 16'h7E81,
                                       16'hFF00, 16'h55AA, 16'h1234, 16'hC3E7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, vblank = 1'b0, pix_stb = 1'b0;
  logic cpu_wr = 1'b0, cpu_addr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic spi_sck, spi_cs_n;
  logic [ND-1:0] spi_mosi, luma_out;
  logic [ND-1:0] spi_miso = '0;

  int nchk = 0, nfail = 0, moderr = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitslice_spi_loader #(.N_DEV(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .vblank(vblank),
    .pix_stb(pix_stb), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .luma_out(luma_out)
  );

  // behavioural serial memories, one per bit-plane
  int bcnt = 0;
  logic [7:0]  opc     [ND];
  logic [15:0] adr     [ND];
  logic [7:0]  din     [ND];
  logic        wel     [ND];
  logic [7:0]  hdr_opc [ND];
  logic [15:0] hdr_adr [ND];
  logic [7:0]  mem     [ND][64];

  initial begin
    for (int k = 0; k < ND; k++) begin
      opc[k] = '0; adr[k] = '0; din[k] = '0; wel[k] = 1'b0;
      hdr_opc[k] = '0; hdr_adr[k] = '0;
      for (int a = 0; a < 64; a++) mem[k][a] = 8'h00;
    end
  end

  always @(posedge spi_sck) begin
    pulses++;
    if (!spi_cs_n) begin
      for (int k = 0; k < ND; k++) begin
        if (bcnt < 8) begin
          opc[k] = {opc[k][6:0], spi_mosi[k]};
          if (bcnt == 7 && opc[k] == 8'h06) wel[k] = 1'b1;
        end else if (bcnt < 24) begin
          adr[k] = {adr[k][14:0], spi_mosi[k]};
          if (bcnt == 23) begin hdr_opc[k] = opc[k]; hdr_adr[k] = adr[k]; end
        end else if (opc[k] == 8'h02 && wel[k]) begin
          din[k] = {din[k][6:0], spi_mosi[k]};
          if (((bcnt - 24) % 8) == 7) begin
            mem[k][adr[k][5:0]] = din[k];
            adr[k] = adr[k] + 16'd1;
          end
        end
      end
      bcnt++;
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && bcnt >= 24) begin
      for (int k = 0; k < ND; k++)
        if (opc[k] == 8'h03)
          spi_miso[k] = mem[k][(int'(hdr_adr[k][5:0]) + (bcnt - 24) / 8) % 64][7 - ((bcnt - 24) % 8)];
    end
  end

  always @(posedge spi_cs_n) begin
    for (int k = 0; k < ND; k++) if (opc[k] == 8'h02) wel[k] = 1'b0;
    bcnt = 0;
  end

  // mode-0 monitor: data settled in the clock before the rising edge
  logic [ND-1:0] prev_mosi = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sck && spi_mosi != prev_mosi) moderr++;
      if (spi_cs_n && spi_sck) moderr++;
    end
    prev_mosi = spi_mosi;
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl(bit v);
    cpu_wr = 1'b1; cpu_addr = 1'b0; cpu_wdata = {7'b0, v};
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic dat(logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = 1'b1; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
    tick(2);
  endtask

  task automatic pix();
    pix_stb = 1'b1;
    tick();
    pix_stb = 1'b0;
    tick();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int p0;
    tick(3);
    // R1 reset state
    chk("R1 cs_n in reset", spi_cs_n, 1);
    chk("R1 sck in reset", spi_sck, 0);
    chk("R1 mosi in reset", spi_mosi, 0);
    chk("R1 luma in reset", luma_out, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 cs_n after reset", spi_cs_n, 1);

    // R8: data write with no session
    p0 = pulses;
    cpu_wr = 1'b1; cpu_addr = 1'b1; cpu_wdata = 8'hC0;
    tick();
    cpu_wr = 1'b0;
    tick(3);
    chk("R8 idle data write pulses", pulses - p0, 0);
    chk("R8 idle data write cs_n", spi_cs_n, 1);

    // R6: open session, WREN then program header
    p0 = pulses;
    ctl(1'b1);
    chk("R6 first gap", spi_cs_n, 1);
    tick(16);
    chk("R6 wren selected", spi_cs_n, 0);
    tick();
    chk("R6 gap after wren", spi_cs_n, 1);
    chk("R6 wren pulses", pulses - p0, 8);
    chk("R6 wel set dev0", wel[0], 1);
    chk("R6 wel set dev1", wel[1], 1);
    tick(49);
    chk("R6 prog opcode dev0", hdr_opc[0], 8'h02);
    chk("R6 prog opcode dev1", hdr_opc[1], 8'h02);
    chk("R6 prog address", hdr_adr[0] | hdr_adr[1], 0);
    chk("R6 cs_n held low", spi_cs_n, 0);

    // R7: table walk, one bit per device per write
    for (int e = 0; e < NV; e++)
      for (int i = 7; i >= 0; i--)
        dat({VEC[e][8+i], VEC[e][i], 6'b101011});

    // R9: close commits
    ctl(1'b0);
    chk("R9 close releases cs_n", spi_cs_n, 1);
    for (int e = 0; e < NV; e++) begin
      chk("R7 stored dev0", mem[0][e], VEC[e][15:8]);
      chk("R7 stored dev1", mem[1][e], VEC[e][7:0]);
    end

    // R2: frame read header
    p0 = pulses;
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    chk("R2 gap before read", spi_cs_n, 1);
    tick();
    chk("R2 read selected", spi_cs_n, 0);
    tick(48);
    chk("R2 header pulses", pulses - p0, 24);
    chk("R2 read opcode dev0", hdr_opc[0], 8'h03);
    chk("R2 read opcode dev1", hdr_opc[1], 8'h03);
    chk("R2 read address", hdr_adr[0] | hdr_adr[1], 0);

    // R3: stream every loaded bit to luma
    for (int p = 0; p < NV * 8; p++) begin
      pix();
      chk("R3 luma stream", luma_out, {VEC[p/8][7-(p%8)], VEC[p/8][8+7-(p%8)]});
    end

    // R11: restart mid-read
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    chk("R11 restart gap", spi_cs_n, 1);
    tick(49);
    p0 = pulses;
    pix_stb = 1'b1;
    tick(2);
    pix_stb = 1'b0;
    tick();
    chk("R11 first bit after restart", luma_out, {VEC[0][7], VEC[0][15]});
    chk("R3 strobe during sck high ignored", pulses - p0, 1);
    pix();
    chk("R3 next bit not skipped", luma_out, {VEC[0][6], VEC[0][14]});

    // R5: blanking releases select and masks frame_start
    vblank = 1'b1;
    tick();
    chk("R5 vblank releases cs_n", spi_cs_n, 1);
    p0 = pulses;
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    tick(5);
    chk("R5 frame_start in vblank cs_n", spi_cs_n, 1);
    chk("R5 frame_start in vblank pulses", pulses - p0, 0);
    pix();
    chk("R3 strobe outside read luma", luma_out, {VEC[0][6], VEC[0][14]});
    chk("R3 strobe outside read pulses", pulses - p0, 0);
    vblank = 1'b0;
    tick();

    // R10: open request and frame_start together
    for (int k = 0; k < ND; k++) wel[k] = 1'b0;
    frame_start = 1'b1;
    ctl(1'b1);
    frame_start = 1'b0;
    tick(17);
    chk("R10 load wins gap", spi_cs_n, 1);
    chk("R10 load wins wel", wel[0] & wel[1], 1);
    tick(49);
    frame_start = 1'b1; vblank = 1'b1;
    tick();
    frame_start = 1'b0;
    tick(3);
    chk("R10 session ignores frame and vblank", spi_cs_n, 0);
    chk("R10 header unchanged", hdr_opc[0], 8'h02);
    vblank = 1'b0;

    // R8: back-to-back data write
    p0 = pulses;
    cpu_wr = 1'b1; cpu_addr = 1'b1; cpu_wdata = 8'hFF;
    tick(2);
    cpu_wr = 1'b0;
    tick(3);
    chk("R8 back-to-back pulses", pulses - p0, 1);
    ctl(1'b0);
    chk("R9 close second session", spi_cs_n, 1);
    chk("R8 partial byte not stored", mem[0][0], VEC[0][15:8]);

    chk("R4 mode 0 monitor", moderr, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule